// File: doc/BRIEF.md
# Cascadable Channel Sum Tree

This block sits at the tail of a multi-channel transmit datapath. Every clock it takes four signed channel samples and adds them. The four-channel total is divided by a programmable power of two. The result is then added to a cascade input that carries the output of an upstream device, so that several devices can be chained into one summed stream. The combined value is rounded to a selectable precision and clamped to full scale on overflow. The final value can be recoded to offset binary for a DAC.

The pipeline is fixed at seven registers from any input to the output. Each sample carries its own copy of the configuration through the pipeline. A change to scale, precision or MSB inversion therefore applies exactly to the samples that enter after the change. The internal sums carry enough guard bits that nothing wraps before the final clamp.

Top module: `chan_sum_tree`

## Requirements
- R1: A synchronous reset clears every pipeline register, so `sum_o` reads 0 while reset is held and in the first cycle after it is released.
- R2: The four 16-bit two's complement channel inputs are added on every clock, with no intermediate wraparound.
- R3: The four-channel total is arithmetically shifted right by `scale_sel_i` (0 to 3) bits, so it rounds toward minus infinity (for example, -5 shifted by 1 gives -3).
- R4: The 16-bit two's complement `casc_i` is added after the shift and is not itself scaled.
- R5: `width_sel_i` codes 0, 1, 2, 3 and 4 select 16, 14, 12, 10 and 8 output bits, and codes 5 to 7 also select 8 bits. The value is rounded half up by adding half an output LSB and clearing the discarded bits. The result is left-justified in `sum_o`, with the unused low bits at zero.
- R6: Saturation is applied after rounding. Values above the largest code of the selected width clamp to 0x7FFF with the discarded low bits cleared (for example 0x7F00 at 8 bits). Values below -32768 clamp to 0x8000.
- R7: A sample presented on the inputs before clock edge k appears on `sum_o` after clock edge k+6, which is a latency of seven cycles.
- R8: When `offset_bin_i` is 1, bit 15 of the result is inverted, giving offset binary instead of two's complement.
- R9: Configuration inputs are sampled together with the data, so each sample uses the settings that were present when it entered, even when the settings change every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch0_i | input | 16 | Channel 0 sample, two's complement |
| ch1_i | input | 16 | Channel 1 sample, two's complement |
| ch2_i | input | 16 | Channel 2 sample, two's complement |
| ch3_i | input | 16 | Channel 3 sample, two's complement |
| casc_i | input | 16 | Cascade input from the upstream device, two's complement |
| scale_sel_i | input | 2 | Right-shift amount applied to the four-channel total |
| width_sel_i | input | 3 | Output precision code |
| offset_bin_i | input | 1 | Invert the output MSB |
| sum_o | output | 16 | Registered result |

## Verification
Mixed-sign values at full precision with no scaling test the plain addition, so any lost carry or sign error in the adder tree shows. Odd negative totals at each shift amount separate floor shifting from truncation toward zero. A cascade value that is not a multiple of the scale shows whether the cascade is added before or after the shift. Values just below and exactly at half an LSB, at each precision code, test the rounding point. Full-scale inputs, and a value that rounds past the top code, separate saturation from wraparound. A single isolated sample among zeros fixes the exact latency. Settings that change on every cycle show whether each sample keeps its own configuration.

// File: rtl/sts_pkg.sv
package sts_pkg;

  typedef struct packed {
    logic [1:0] shift;
    logic [2:0] wsel;
    logic       inv;
  } sts_cfg_t;

  // number of low bits discarded for a width code
  function automatic int lsb_drop(input logic [2:0] wsel);
    int code;
    code = int'(wsel);
    if (code > 4) code = 4;
    return 2 * code;
  endfunction

  // round half up, then clear the discarded bits
  function automatic logic signed [31:0] round_up_half(input logic signed [31:0] v,
                                                       input int drop);
    logic signed [31:0] half;
    logic signed [31:0] mask;
    half = (drop == 0) ? 32'sd0 : (32'sd1 <<< (drop - 1));
    mask = ~((32'sd1 <<< drop) - 32'sd1);
    return (v + half) & mask;
  endfunction

  // largest positive left-justified code of the chosen precision
  function automatic logic signed [31:0] pos_full(input int dw, input int drop);
    return (32'sd1 <<< (dw - 1)) - (32'sd1 <<< drop);
  endfunction

  function automatic logic signed [31:0] neg_full(input int dw);
    return -(32'sd1 <<< (dw - 1));
  endfunction

endpackage

// File: rtl/sts_add_reg.sv
module sts_add_reg #(
  parameter int AW = 16,
  parameter int YW = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [AW-1:0] a_i,
  input  logic signed [AW-1:0] b_i,
  output logic signed [YW-1:0] y_o
);

  always_ff @(posedge clk) begin
    if (rst) y_o <= '0;
    else     y_o <= YW'(a_i) + YW'(b_i);
  end

endmodule

// File: rtl/sts_round_sat.sv
module sts_round_sat
  import sts_pkg::*;
#(
  parameter int IW = 19,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] sum_i,
  input  sts_cfg_t             cfg_i,
  output logic [DW-1:0]        dout_o
);

  localparam int RW = IW + 1;

  // stage 6: rounding
  logic signed [RW-1:0] rnd_q;
  sts_cfg_t             cfg6;

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_q <= '0;
      cfg6  <= '0;
    end else begin
      rnd_q <= RW'(round_up_half(32'(sum_i), lsb_drop(cfg_i.wsel)));
      cfg6  <= cfg_i;
    end
  end

  // stage 7: clamp and recode
  int                 drop6;
  logic signed [31:0] rnd_w;
  logic signed [31:0] hi_w;
  logic signed [31:0] lo_w;
  logic               sat_hi;
  logic               sat_lo;
  logic signed [31:0] tc_w;
  logic [DW-1:0]      msb_flip;

  always_comb begin
    drop6    = lsb_drop(cfg6.wsel);
    rnd_w    = 32'(rnd_q);
    hi_w     = pos_full(DW, drop6);
    lo_w     = neg_full(DW);
    sat_hi   = rnd_w > hi_w;
    sat_lo   = rnd_w < lo_w;
    tc_w     = sat_hi ? hi_w : (sat_lo ? lo_w : rnd_w);
    msb_flip = {cfg6.inv, {(DW-1){1'b0}}};
  end

  logic          sat_hi_q;
  logic          sat_lo_q;
  logic          inv7;
  logic [DW-1:0] lowmask7;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o   <= '0;
      sat_hi_q <= 1'b0;
      sat_lo_q <= 1'b0;
      inv7     <= 1'b0;
      lowmask7 <= '0;
    end else begin
      dout_o   <= DW'(tc_w) ^ msb_flip;
      sat_hi_q <= sat_hi;
      sat_lo_q <= sat_lo;
      inv7     <= cfg6.inv;
      lowmask7 <= DW'((32'sd1 <<< drop6) - 32'sd1);
    end
  end

  // output recoded back to two's complement for the checks
  logic [DW-1:0] out_tc;
  assign out_tc = dout_o ^ {inv7, {(DW-1){1'b0}}};

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dout_o & lowmask7) == '0); // R5
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
    sat_hi_q |-> (out_tc[DW-1] == 1'b0 && (&(out_tc[DW-2:0] | lowmask7[DW-2:0])))); // R6
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
    sat_lo_q |-> out_tc == {1'b1, {(DW-1){1'b0}}}); // R6

endmodule

// File: rtl/chan_sum_tree.sv
module chan_sum_tree
  import sts_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ch0_i,
  input  logic [DW-1:0] ch1_i,
  input  logic [DW-1:0] ch2_i,
  input  logic [DW-1:0] ch3_i,
  input  logic [DW-1:0] casc_i,
  input  logic [1:0]    scale_sel_i,
  input  logic [2:0]    width_sel_i,
  input  logic          offset_bin_i,
  output logic [DW-1:0] sum_o
);

  localparam int NCH = 4;
  localparam int NPR = NCH / 2;
  localparam int PW  = DW + 1;   // pair sum
  localparam int TW  = DW + 2;   // four-channel sum
  localparam int AW  = DW + 3;   // with cascade

  // stage 1: input capture
  logic signed [DW-1:0] ch_q [NCH];
  logic signed [DW-1:0] casc1, casc2, casc3, casc4;
  sts_cfg_t             cfg1, cfg2, cfg3, cfg4, cfg5;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) ch_q[i] <= '0;
      casc1 <= '0;
      cfg1  <= '0;
    end else begin
      ch_q[0] <= ch0_i;
      ch_q[1] <= ch1_i;
      ch_q[2] <= ch2_i;
      ch_q[3] <= ch3_i;
      casc1   <= casc_i;
      cfg1    <= '{shift: scale_sel_i, wsel: width_sel_i, inv: offset_bin_i};
    end
  end

  // stage 2: pair sums
  logic signed [PW-1:0] pair_q [NPR];

  for (genvar g = 0; g < NPR; g++) begin : g_pair
    sts_add_reg #(.AW(DW), .YW(PW)) u_pair (
      .clk (clk),
      .rst (rst),
      .a_i (ch_q[2*g]),
      .b_i (ch_q[2*g+1]),
      .y_o (pair_q[g])
    );
  end

  // stage 3: four-channel sum
  logic signed [TW-1:0] tot_q;

  sts_add_reg #(.AW(PW), .YW(TW)) u_total (
    .clk (clk),
    .rst (rst),
    .a_i (pair_q[0]),
    .b_i (pair_q[1]),
    .y_o (tot_q)
  );

  // side chain for cascade and config, stages 2..5
  always_ff @(posedge clk) begin
    if (rst) begin
      casc2 <= '0; casc3 <= '0; casc4 <= '0;
      cfg2  <= '0; cfg3  <= '0; cfg4  <= '0; cfg5 <= '0;
    end else begin
      casc2 <= casc1; casc3 <= casc2; casc4 <= casc3;
      cfg2  <= cfg1;  cfg3  <= cfg2;  cfg4  <= cfg3;  cfg5 <= cfg4;
    end
  end

  // stage 4: power-of-two scaling (floor)
  logic signed [TW-1:0] scl_q;
  // stage 5: cascade add
  logic signed [AW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '0;
      acc_q <= '0;
    end else begin
      scl_q <= tot_q >>> cfg3.shift;
      acc_q <= AW'(scl_q) + AW'(casc4);
    end
  end

  // stages 6, 7: round, clamp, recode
  sts_round_sat #(.IW(AW), .DW(DW)) u_round_sat (
    .clk    (clk),
    .rst    (rst),
    .sum_i  (acc_q),
    .cfg_i  (cfg5),
    .dout_o (sum_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sum_o == '0); // R1

endmodule

// File: tb/chan_sum_tree_bench.sv
module chan_sum_tree_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ch0, ch1, ch2, ch3, casc;
  logic [1:0]  ssel;
  logic [2:0]  wsel;
  logic        inv;
  logic [15:0] sum_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int          due;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  chan_sum_tree u_chan_sum_tree (
    .clk          (clk),
    .rst          (rst),
    .ch0_i        (ch0),
    .ch1_i        (ch1),
    .ch2_i        (ch2),
    .ch3_i        (ch3),
    .casc_i       (casc),
    .scale_sel_i  (ssel),
    .width_sel_i  (wsel),
    .offset_bin_i (inv),
    .sum_o        (sum_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // floor division by a positive divisor
  function automatic int floor_div(int x, int d);
    int r;
    r = x % d;
    if (r < 0) r += d;
    return (x - r) / d;
  endfunction

  function automatic logic [15:0] model(int c0, int c1, int c2, int c3, int cs,
                                        int s, int w, bit iv);
    int v, nb, unit, top;
    logic [15:0] o;
    v  = floor_div(c0 + c1 + c2 + c3, 1 << s) + cs;
    nb = (w > 4) ? 8 : 2 * w;
    unit = 1 << nb;
    if (nb > 0) v = floor_div(v + unit / 2, unit) * unit;
    top = 32768 - unit;
    if (v > top)    v = top;
    if (v < -32768) v = -32768;
    o = v[15:0];
    if (iv) o[15] = ~o[15];
    return o;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sum_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(int c0, int c1, int c2, int c3, int cs,
                      int s, int w, bit iv, string tag);
    item_t it;
    @(negedge clk);
    ch0 = 16'(c0); ch1 = 16'(c1); ch2 = 16'(c2); ch3 = 16'(c3);
    casc = 16'(cs); ssel = 2'(s); wsel = 3'(w); inv = iv;
    it.due = cyc + LAT;
    it.exp = model(c0, c1, c2, c3, cs, s, w, iv);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare each result in the cycle it is due
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, sum_o, it.exp);
      end
    end
  end

  initial begin
    ch0 = '0; ch1 = '0; ch2 = '0; ch3 = '0; casc = '0;
    ssel = '0; wsel = '0; inv = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 during reset", sum_o, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 after release", sum_o, 16'h0000);

    // R2 plain sums
    send(100, 200, -50, 7, 0, 0, 0, 0, "R2 mixed");
    send(-1000, -2000, 3000, 4000, 0, 0, 0, 0, "R2 mixed2");
    send(32767, -32768, 12345, -12345, 0, 0, 0, 0, "R2 extremes cancel");
    // R3 floor shift
    send(-5, 0, 0, 0, 0, 1, 0, 0, "R3 -5>>1");
    send(-7, 0, 0, 0, 0, 2, 0, 0, "R3 -7>>2");
    send(30000, 30000, 30000, 30000, 0, 3, 0, 0, "R3 big>>3");
    send(-3, -4, 0, 0, 0, 3, 0, 0, "R3 -7>>3");
    // R4 cascade after shift
    send(4, 1, 0, 0, 100, 2, 0, 0, "R4 cascade unscaled");
    send(-9, 0, 0, 0, -1001, 1, 0, 0, "R4 cascade neg");
    // R5 rounding widths
    send(128, 0, 0, 0, 0, 0, 4, 0, "R5 half at 8b");
    send(127, 0, 0, 0, 0, 0, 4, 0, "R5 below half at 8b");
    send(-129, 0, 0, 0, 0, 0, 4, 0, "R5 neg at 8b");
    send(2, 0, 0, 0, 0, 0, 1, 0, "R5 half at 14b");
    send(1, 0, 0, 0, 0, 0, 1, 0, "R5 below half 14b");
    send(2047, 0, 0, 0, 0, 0, 3, 0, "R5 10b");
    send(32, 0, 0, 0, 0, 0, 2, 0, "R5 12b");
    send(128, 0, 0, 0, 0, 0, 7, 0, "R5 code7 as 8b");
    send(1000, 0, 0, 0, 0, 0, 5, 0, "R5 code5 as 8b");
    // R6 saturation
    send(32767, 32767, 32767, 32767, 32767, 0, 0, 0, "R6 clamp high");
    send(-32768, -32768, -32768, -32768, -32768, 0, 0, 0, "R6 clamp low");
    send(32767, 0, 0, 0, 0, 0, 4, 0, "R6 round carry clamp");
    send(32767, 32767, 32767, 32767, 32767, 3, 2, 0, "R6 clamp 12b");
    // R8 offset binary
    send(0, 0, 0, 0, 0, 0, 0, 1, "R8 zero offset");
    send(-100, 0, 0, 0, 0, 0, 0, 1, "R8 negative offset");
    send(32767, 32767, 0, 0, 0, 0, 0, 1, "R8 clamp offset");
    // R9 per-sample config
    send(-5, 0, 0, 0, 10, 0, 0, 1, "R9 cfg a");
    send(-5, 0, 0, 0, 10, 1, 4, 0, "R9 cfg b");
    send(-5, 0, 0, 0, 10, 2, 2, 1, "R9 cfg c");
    send(-5, 0, 0, 0, 10, 3, 0, 0, "R9 cfg d");
    // R7 isolated pulse
    for (int i = 0; i < 8; i++) send(0, 0, 0, 0, 0, 0, 0, 0, "R7 zeros before");
    send(1111, 0, 0, 0, 0, 0, 0, 0, "R7 pulse");
    for (int i = 0; i < 8; i++) send(0, 0, 0, 0, 0, 0, 0, 0, "R7 zeros after");
    // R2 random stream
    for (int i = 0; i < 60; i++) begin
      send(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))), int'($urandom % 4),
           int'($urandom % 8), bit'($urandom % 2), "R2 random");
    end
    send(0, 0, 0, 0, 0, 0, 0, 0, "R7 tail");
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule